// File: doc/BRIEF.md
# Daisy-Chained I2C Target Address Assignment

This block is the address stage of an I2C target that sits in a chain of identical devices on one shared bus. None of the devices has address pins. Each device waits for its chain-enable input to be pulled low by the device ahead of it, or tied low for the first one. It then answers one common start-up address, and the host sends it one write that gives it its own address. Once that write succeeds, the device drives its chain-done output low. That output feeds the chain-enable input of the next device, which then becomes the only device answering the start-up address.

After assignment, the address is frozen. The chain-enable input no longer affects addressing. The block then decodes each address byte from the host into one of three targets: its own register address, a write-only broadcast address shared by every device, or a window of sixteen addresses tied to its instance number. Inside that window, the address selects one of four ports and one of two logical downstream devices. The downstream address of each logical device is held in a programmable register, and the register for the selected device is reported with the decoded port.

The bit-level SCL/SDA engine sits outside this block. It presents the address byte and each written data byte as one-cycle events and reads back the acknowledge decision in the same cycle.

Top module: `i2c_chain_addr`

## Requirements
- R1: While the block is unassigned and `chain_in_n` is high, `ack` stays 0 for every address byte, including 0x1E.
- R2: While the block is unassigned and `chain_in_n` is low, the address byte 0x1E (write) is acknowledged. Every other byte, including 0x1F, 0x02 and 0x04, is not acknowledged.
- R3: In a transaction to 0x1E, the first data byte, with bit 0 forced to 0, becomes the self-address if the result is even and lies from 0x04 to 0x1E. The byte is acknowledged, and from the next cycle `chain_done_oe` is 1 with `chain_done_n` at 0 and `self_addr` showing the new value.
- R4: A first data byte whose forced-even value lies outside 0x04 to 0x1E (for example 0x00 or 0x20) is not acknowledged. `chain_done_oe` stays 0 and `self_addr` stays 0x1E.
- R5: Once assigned, the self-address cannot change. The address byte 0x1E is not acknowledged unless it equals the self-address, a second data byte in the assignment transaction is not acknowledged, and `chain_in_n` has no effect.
- R6: A power-on reset, or `en` sampled low, returns the block to the unassigned state. After this, `chain_done_oe` is 0, `self_addr` is 0x1E, and both logical-device registers hold their defaults.
- R7: Once assigned, the write address 0x02 is acknowledged and sets `sel_bcast`. The read byte 0x03 is never acknowledged.
- R8: Once assigned, an address byte whose bits [7:1] equal the self-address is acknowledged for both read and write and sets `sel_self`. Each select output is cleared by `ev_stop`, and at most one select output is 1 at a time.
- R9: With instance n = (self-address − 0x04)/2, the bytes 0x20+0x10·n through 0x2F+0x10·n are acknowledged and set `sel_port`. In that window, offset bits [3:2] give `port_num` and offset bit 1 gives `ldev_sel`. A byte outside the window that matches no other target is not acknowledged and sets no select.
- R10: The logical-device registers reset to 0xA0 (device 0) and 0xA2 (device 1), and `ldev_addr` shows the register chosen by `ldev_sel`. A write to the self-address or to the broadcast address takes a first data byte as the register index: 0 or 1 is acknowledged, and anything else is not acknowledged and ends the transaction. The second data byte is acknowledged and written to that register. Any later byte is not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| en | input | 1 | Device enable; when low, all state is cleared |
| chain_in_n | input | 1 | Chain-enable from the previous device, active low, pulled high outside the block |
| ev_addr | input | 1 | One-cycle pulse: `ev_byte` holds an address byte (bit 0 is read/write) |
| ev_data | input | 1 | One-cycle pulse: `ev_byte` holds a written data byte |
| ev_stop | input | 1 | One-cycle pulse: the bus transaction has ended |
| ev_byte | input | 8 | Address or data byte |
| ack | output | 1 | Acknowledge decision for the byte of the current event, combinational |
| chain_done_n | output | 1 | Chain-done level driven to the next device, always 0 |
| chain_done_oe | output | 1 | Drive enable for `chain_done_n`; 0 means high impedance |
| self_addr | output | 8 | Assigned self-address, or 0x1E while unassigned |
| sel_self | output | 1 | The current transaction targets the self-address |
| sel_bcast | output | 1 | The current transaction is a broadcast write |
| sel_port | output | 1 | The current transaction targets the port window |
| port_num | output | 2 | Decoded port inside the window |
| ldev_sel | output | 1 | Decoded logical device inside the window |
| ldev_addr | output | 8 | Downstream address of the selected logical device |

## Verification
The hardest state to reach is the one where the lock must hold while the inputs invite a change. The self-address happens to equal the start-up address 0x1E, or a second assignment byte arrives in the same transaction, or the chain-enable input goes back high. The bench first drives rejected assignment values and checks that the block stays unassigned. It then assigns 0x08 and tries each of those attempts. Next it drops `en` to clear the block, reassigns the last-instance address 0x1E, and confirms two things: a write to 0x1E now lands on the register path rather than the assignment path, and the window moves to 0xF0–0xFF.

// File: rtl/cca_pkg.sv
package cca_pkg;

   typedef enum logic [2:0] {
      TX_IDLE,
      TX_ASSIGN,
      TX_REG,
      TX_PORT,
      TX_READ
   } txn_e;

   function automatic logic self_ok(input logic [7:0] a, input int base, input int n_inst);
      return (a[0] == 1'b0) && (int'(a) >= base) && (int'(a) <= base + 2 * (n_inst - 1));
   endfunction

endpackage

// File: rtl/cca_decode.sv
module cca_decode
   import cca_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DEFAULT_ADDR = 'h1E,
   parameter int BCAST_ADDR   = 'h02,
   parameter int SELF_BASE    = 'h04,
   parameter int WIN_BASE     = 'h20,
   parameter int WIN_STRIDE   = 'h10,
   parameter int PORT_W       = 2,
   parameter int LDEV_W       = 1
) (
   input  logic              chain_in_n,
   input  logic              assigned,
   input  logic [AW-1:0]     self_q,
   input  logic [AW-1:0]     abyte,
   output logic              hit,
   output txn_e              kind,
   output logic              is_self,
   output logic              is_bcast,
   output logic              is_port,
   output logic [PORT_W-1:0] port,
   output logic [LDEV_W-1:0] ldev
);
   localparam int SEL_LSB = 1;
   localparam int PORT_LSB = SEL_LSB + LDEV_W;

   logic [AW-1:0] inst;
   logic [AW-1:0] win_base;
   logic [AW-1:0] offset;
   logic          in_win;
   logic          wr;

   assign inst     = (self_q - AW'(SELF_BASE)) >> 1;
   assign win_base = AW'(WIN_BASE + int'(inst) * WIN_STRIDE);
   assign offset   = abyte - win_base;
   assign in_win   = int'(offset) < WIN_STRIDE;
   assign wr       = ~abyte[0];
   assign port     = offset[PORT_LSB +: PORT_W];
   assign ldev     = offset[SEL_LSB +: LDEV_W];

   always_comb begin
      hit      = 1'b0;
      kind     = TX_IDLE;
      is_self  = 1'b0;
      is_bcast = 1'b0;
      is_port  = 1'b0;
      if (!assigned) begin
         if (!chain_in_n && abyte == AW'(DEFAULT_ADDR)) begin
            hit  = 1'b1;
            kind = TX_ASSIGN;
         end
      end else if (abyte[AW-1:1] == self_q[AW-1:1]) begin
         hit     = 1'b1;
         is_self = 1'b1;
         kind    = wr ? TX_REG : TX_READ;
      end else if (abyte == AW'(BCAST_ADDR)) begin
         hit      = 1'b1;
         is_bcast = 1'b1;
         kind     = TX_REG;
      end else if (in_win) begin
         hit     = 1'b1;
         is_port = 1'b1;
         kind    = TX_PORT;
      end
   end
endmodule

// File: rtl/cca_ctrl.sv
module cca_ctrl
   import cca_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DEFAULT_ADDR = 'h1E,
   parameter int SELF_BASE    = 'h04,
   parameter int NUM_INST     = 14,
   parameter int NUM_LDEV     = 2,
   parameter int PORT_W       = 2,
   parameter int LDEV_W       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ev_addr,
   input  logic              ev_data,
   input  logic              ev_stop,
   input  logic [AW-1:0]     ev_byte,
   input  logic              hit,
   input  txn_e              kind,
   input  logic              is_self,
   input  logic              is_bcast,
   input  logic              is_port,
   input  logic [PORT_W-1:0] port,
   input  logic [LDEV_W-1:0] ldev,
   output logic              assigned,
   output logic [AW-1:0]     self_q,
   output logic              sel_self,
   output logic              sel_bcast,
   output logic              sel_port,
   output logic [PORT_W-1:0] port_q,
   output logic [LDEV_W-1:0] ldev_q,
   output logic              data_ack,
   output logic              wr_en,
   output logic [LDEV_W-1:0] wr_idx
);
   txn_e          txn;
   logic [1:0]    cnt;
   logic [AW-1:0] cand;

   assign cand = {ev_byte[AW-1:1], 1'b0};

   always_comb begin
      data_ack = 1'b0;
      case (txn)
         TX_ASSIGN: data_ack = !assigned && self_ok(cand, SELF_BASE, NUM_INST);
         TX_REG:    data_ack = (cnt == 2'd0) ? (int'(ev_byte) < NUM_LDEV) : (cnt == 2'd1);
         TX_PORT:   data_ack = 1'b1;
         default:   data_ack = 1'b0;
      endcase
   end

   assign wr_en = en && ev_data && txn == TX_REG && cnt == 2'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txn <= TX_IDLE; cnt <= '0; wr_idx <= '0;
         assigned <= 1'b0; self_q <= AW'(DEFAULT_ADDR);
         sel_self <= 1'b0; sel_bcast <= 1'b0; sel_port <= 1'b0;
         port_q <= '0; ldev_q <= '0;
      end else if (!en) begin
         txn <= TX_IDLE; cnt <= '0; wr_idx <= '0;
         assigned <= 1'b0; self_q <= AW'(DEFAULT_ADDR);
         sel_self <= 1'b0; sel_bcast <= 1'b0; sel_port <= 1'b0;
         port_q <= '0; ldev_q <= '0;
      end else if (ev_stop) begin
         txn <= TX_IDLE;
         sel_self <= 1'b0; sel_bcast <= 1'b0; sel_port <= 1'b0;
      end else if (ev_addr) begin
         txn       <= hit ? kind : TX_IDLE;
         cnt       <= '0;
         sel_self  <= hit && is_self;
         sel_bcast <= hit && is_bcast;
         sel_port  <= hit && is_port;
         port_q    <= (hit && is_port) ? port : '0;
         ldev_q    <= (hit && is_port) ? ldev : '0;
      end else if (ev_data) begin
         if (cnt != 2'd3) cnt <= cnt + 2'd1;
         if (txn == TX_ASSIGN && data_ack) begin
            assigned <= 1'b1;
            self_q   <= cand;
         end
         if (txn == TX_REG && cnt == 2'd0) begin
            wr_idx <= ev_byte[LDEV_W-1:0];
            if (!data_ack) txn <= TX_IDLE;
         end
      end
   end
endmodule

// File: rtl/cca_ldev_regs.sv
module cca_ldev_regs #(
   parameter int AW        = 8,
   parameter int NUM_LDEV  = 2,
   parameter int LDEV_W    = 1,
   parameter int LDEV_BASE = 'hA0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_en,
   input  logic [LDEV_W-1:0] wr_idx,
   input  logic [AW-1:0]     wr_val,
   input  logic [LDEV_W-1:0] rd_idx,
   output logic [AW-1:0]     rd_val
);
   logic [AW-1:0] regs [NUM_LDEV];

   for (genvar i = 0; i < NUM_LDEV; i++) begin : g_reg
      localparam logic [AW-1:0] RST = AW'(LDEV_BASE + 2 * i);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                 regs[i] <= RST;
         else if (!en)                               regs[i] <= RST;
         else if (wr_en && int'(wr_idx) == i)        regs[i] <= wr_val;
      end
   end

   assign rd_val = regs[rd_idx];
endmodule

// File: rtl/i2c_chain_addr.sv
module i2c_chain_addr
   import cca_pkg::*;
#(
   parameter int AW           = 8,
   parameter int DEFAULT_ADDR = 'h1E,
   parameter int BCAST_ADDR   = 'h02,
   parameter int SELF_BASE    = 'h04,
   parameter int NUM_INST     = 14,
   parameter int WIN_BASE     = 'h20,
   parameter int NUM_PORTS    = 4,
   parameter int NUM_LDEV     = 2,
   parameter int LDEV_BASE    = 'hA0,
   localparam int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
   localparam int LDEV_W      = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              chain_in_n,
   input  logic              ev_addr,
   input  logic              ev_data,
   input  logic              ev_stop,
   input  logic [AW-1:0]     ev_byte,
   output logic              ack,
   output logic              chain_done_n,
   output logic              chain_done_oe,
   output logic [AW-1:0]     self_addr,
   output logic              sel_self,
   output logic              sel_bcast,
   output logic              sel_port,
   output logic [PORT_W-1:0] port_num,
   output logic [LDEV_W-1:0] ldev_sel,
   output logic [AW-1:0]     ldev_addr
);
   localparam int WIN_STRIDE = 2 * NUM_PORTS * NUM_LDEV;

   if (AW != 8) begin : g_bad_aw
      $error("address width must be 8");
   end
   if (SELF_BASE + 2 * (NUM_INST - 1) != DEFAULT_ADDR) begin : g_bad_default
      $error("start-up address must be the last instance self-address");
   end
   if ((DEFAULT_ADDR % 2) != 0 || (SELF_BASE % 2) != 0) begin : g_bad_parity
      $error("addresses must be even");
   end
   if (WIN_BASE + WIN_STRIDE * NUM_INST > (1 << AW)) begin : g_bad_win
      $error("port windows exceed address space");
   end

   logic              hit, is_self, is_bcast, is_port, assigned, data_ack, wr_en;
   txn_e              kind;
   logic [PORT_W-1:0] port;
   logic [LDEV_W-1:0] ldev, wr_idx;
   logic [AW-1:0]     self_q;

   cca_decode #(
      .AW(AW), .DEFAULT_ADDR(DEFAULT_ADDR), .BCAST_ADDR(BCAST_ADDR), .SELF_BASE(SELF_BASE),
      .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE), .PORT_W(PORT_W), .LDEV_W(LDEV_W)
   ) u_dec (
      .chain_in_n(chain_in_n), .assigned(assigned), .self_q(self_q), .abyte(ev_byte),
      .hit(hit), .kind(kind), .is_self(is_self), .is_bcast(is_bcast), .is_port(is_port),
      .port(port), .ldev(ldev)
   );

   cca_ctrl #(
      .AW(AW), .DEFAULT_ADDR(DEFAULT_ADDR), .SELF_BASE(SELF_BASE), .NUM_INST(NUM_INST),
      .NUM_LDEV(NUM_LDEV), .PORT_W(PORT_W), .LDEV_W(LDEV_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .en(en), .ev_addr(ev_addr), .ev_data(ev_data),
      .ev_stop(ev_stop), .ev_byte(ev_byte), .hit(hit), .kind(kind), .is_self(is_self),
      .is_bcast(is_bcast), .is_port(is_port), .port(port), .ldev(ldev),
      .assigned(assigned), .self_q(self_q), .sel_self(sel_self), .sel_bcast(sel_bcast),
      .sel_port(sel_port), .port_q(port_num), .ldev_q(ldev_sel), .data_ack(data_ack),
      .wr_en(wr_en), .wr_idx(wr_idx)
   );

   cca_ldev_regs #(
      .AW(AW), .NUM_LDEV(NUM_LDEV), .LDEV_W(LDEV_W), .LDEV_BASE(LDEV_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_val(ev_byte), .rd_idx(ldev_sel), .rd_val(ldev_addr)
   );

   assign ack           = en && ((ev_addr && hit) || (!ev_addr && ev_data && data_ack));
   assign chain_done_n  = 1'b0;
   assign chain_done_oe = assigned;
   assign self_addr     = self_q;
endmodule

// File: rtl/cca_chk.sv
module cca_chk #(
   parameter int AW = 8,
   parameter int PW = 2,
   parameter int LW = 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          en,
   input logic          chain_in_n,
   input logic          ev_addr,
   input logic          ev_data,
   input logic [AW-1:0] ev_byte,
   input logic          ack,
   input logic          chain_done_oe,
   input logic [AW-1:0] self_addr,
   input logic          sel_self,
   input logic          sel_bcast,
   input logic          sel_port
);
   // R1
   gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr && !chain_done_oe && chain_in_n) |-> !ack);

   // R3
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_done_oe) |-> $past(ev_data && ack));

   // R5
   addr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chain_done_oe |=> (!chain_done_oe || $stable(self_addr)));

   // R6
   enable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!chain_done_oe && self_addr == 8'h1E));

   // R7
   bcast_read_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_addr && ev_byte == 8'h03) |-> !ack);

   // R8
   one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_self, sel_bcast, sel_port}));
endmodule

bind i2c_chain_addr cca_chk #(.AW(AW), .PW(PORT_W), .LW(LDEV_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .chain_in_n(chain_in_n), .ev_addr(ev_addr),
   .ev_data(ev_data), .ev_byte(ev_byte), .ack(ack), .chain_done_oe(chain_done_oe),
   .self_addr(self_addr), .sel_self(sel_self), .sel_bcast(sel_bcast), .sel_port(sel_port)
);

// File: tb/sim_i2c_chain_addr.sv
module sim_i2c_chain_addr;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, chain_in_n = 1'b1;
   logic ev_addr = 1'b0, ev_data = 1'b0, ev_stop = 1'b0;
   logic [7:0] ev_byte = 8'h00;
   logic ack, chain_done_n, chain_done_oe, sel_self, sel_bcast, sel_port, ldev_sel;
   logic [7:0] self_addr, ldev_addr;
   logic [1:0] port_num;

   int nchk = 0, nfail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   i2c_chain_addr u0 (
      .clk(clk), .rst_n(rst_n), .en(en), .chain_in_n(chain_in_n), .ev_addr(ev_addr),
      .ev_data(ev_data), .ev_stop(ev_stop), .ev_byte(ev_byte), .ack(ack),
      .chain_done_n(chain_done_n), .chain_done_oe(chain_done_oe), .self_addr(self_addr),
      .sel_self(sel_self), .sel_bcast(sel_bcast), .sel_port(sel_port),
      .port_num(port_num), .ldev_sel(ldev_sel), .ldev_addr(ldev_addr)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic send_addr(input logic [7:0] b, output logic a);
      ev_addr = 1'b1; ev_byte = b;
      #1 a = ack;
      @(negedge clk); ev_addr = 1'b0;
   endtask

   task automatic send_data(input logic [7:0] b, output logic a);
      ev_data = 1'b1; ev_byte = b;
      #1 a = ack;
      @(negedge clk); ev_data = 1'b0;
   endtask

   task automatic send_stop();
      ev_stop = 1'b1;
      @(negedge clk); ev_stop = 1'b0;
   endtask

   task automatic t_reset();
      check("R6", "reset oe", chain_done_oe, 0);
      check("R6", "reset self", self_addr, 8'h1E);
      check("R10", "reset ldev0", ldev_addr, 8'hA0);
      check("R8", "reset sels", {sel_self, sel_bcast, sel_port}, 0);
   endtask

   task automatic t_gate_closed();
      logic a;
      chain_in_n = 1'b1;
      send_addr(8'h1E, a); check("R1", "default while gate high", a, 0);
      send_stop();
      send_addr(8'h02, a); check("R1", "bcast while gate high", a, 0);
      send_stop();
   endtask

   task automatic t_default_only();
      logic a;
      chain_in_n = 1'b0;
      send_addr(8'h1E, a); check("R2", "default ack", a, 1);
      send_stop();
      send_addr(8'h1F, a); check("R2", "default read", a, 0);
      send_addr(8'h02, a); check("R2", "bcast unassigned", a, 0);
      send_addr(8'h04, a); check("R2", "0x04 unassigned", a, 0);
      send_stop();
   endtask

   task automatic t_bad_assign();
      logic a;
      send_addr(8'h1E, a);
      send_data(8'h20, a); check("R4", "0x20 rejected", a, 0);
      send_stop();
      send_addr(8'h1E, a);
      send_data(8'h01, a); check("R4", "0x00 rejected", a, 0);
      send_stop();
      check("R4", "oe after bad", chain_done_oe, 0);
      check("R4", "self after bad", self_addr, 8'h1E);
   endtask

   task automatic t_assign();
      logic a;
      send_addr(8'h1E, a);
      send_data(8'h09, a); check("R3", "assign ack", a, 1);
      check("R3", "oe", chain_done_oe, 1);
      check("R3", "done level", chain_done_n, 0);
      check("R3", "self forced even", self_addr, 8'h08);
      send_data(8'h0A, a); check("R5", "second assign byte", a, 0);
      send_stop();
      check("R5", "self kept", self_addr, 8'h08);
   endtask

   task automatic t_lock();
      logic a;
      chain_in_n = 1'b1;
      send_addr(8'h08, a); check("R5", "self ack gate high", a, 1);
      send_stop();
      send_addr(8'h1E, a); check("R5", "default after lock", a, 0);
      send_stop();
      chain_in_n = 1'b0;
      send_addr(8'h1E, a); check("R5", "default gate low", a, 0);
      send_stop();
      check("R5", "self still", self_addr, 8'h08);
   endtask

   task automatic t_bcast();
      logic a;
      send_addr(8'h02, a); check("R7", "bcast write", a, 1);
      check("R7", "sel_bcast", sel_bcast, 1);
      send_stop();
      check("R8", "sel clear", sel_bcast, 0);
      send_addr(8'h03, a); check("R7", "bcast read", a, 0);
      send_stop();
   endtask

   task automatic t_self();
      logic a;
      send_addr(8'h09, a); check("R8", "self read", a, 1);
      check("R8", "sel_self", sel_self, 1);
      send_stop();
      check("R8", "sel_self clear", sel_self, 0);
   endtask

   task automatic t_window();
      logic a;
      send_addr(8'h4A, a); check("R9", "window ack", a, 1);
      check("R9", "sel_port", sel_port, 1);
      check("R9", "port", port_num, 2);
      check("R9", "ldev", ldev_sel, 1);
      check("R10", "ldev1 default", ldev_addr, 8'hA2);
      send_stop();
      send_addr(8'h50, a); check("R9", "above window", a, 0);
      check("R9", "no sel above", {sel_self, sel_bcast, sel_port}, 0);
      send_addr(8'h3E, a); check("R9", "below window", a, 0);
      send_stop();
      send_addr(8'h40, a);
      check("R9", "port0", port_num, 0);
      check("R9", "ldev0", ldev_sel, 0);
      send_stop();
   endtask

   task automatic t_ldev_regs();
      logic a;
      send_addr(8'h08, a);
      send_data(8'h01, a); check("R10", "index 1", a, 1);
      send_data(8'hB4, a); check("R10", "value", a, 1);
      send_data(8'h55, a); check("R10", "extra byte", a, 0);
      send_stop();
      send_addr(8'h4E, a);
      check("R9", "port3", port_num, 3);
      check("R10", "ldev1 written", ldev_addr, 8'hB4);
      send_stop();
      send_addr(8'h08, a);
      send_data(8'h02, a); check("R10", "bad index", a, 0);
      send_data(8'h77, a); check("R10", "after bad index", a, 0);
      send_stop();
      send_addr(8'h02, a);
      send_data(8'h00, a);
      send_data(8'hC0, a); check("R10", "bcast value", a, 1);
      send_stop();
      send_addr(8'h44, a);
      check("R9", "port1", port_num, 1);
      check("R10", "ldev0 via bcast", ldev_addr, 8'hC0);
      send_stop();
   endtask

   task automatic t_reenable();
      logic a;
      chain_in_n = 1'b1;
      en = 1'b0;
      @(negedge clk); @(negedge clk);
      en = 1'b1;
      @(negedge clk);
      check("R6", "oe cleared", chain_done_oe, 0);
      check("R6", "self default", self_addr, 8'h1E);
      check("R6", "ldev default", ldev_addr, 8'hA0);
      send_addr(8'h08, a); check("R6", "old self gone", a, 0);
      send_stop();
      chain_in_n = 1'b0;
      send_addr(8'h1E, a);
      send_data(8'h1E, a); check("R3", "assign last", a, 1);
      send_stop();
      check("R3", "self last", self_addr, 8'h1E);
      send_addr(8'hFC, a); check("R9", "last window", a, 1);
      check("R9", "last port", port_num, 3);
      send_stop();
      send_addr(8'h1E, a);
      send_data(8'h00, a); check("R5", "0x1E goes to registers", a, 1);
      send_data(8'hA8, a);
      send_stop();
      check("R5", "self last kept", self_addr, 8'h1E);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_gate_closed();
      t_default_only();
      t_bad_assign();
      t_assign();
      t_lock();
      t_bcast();
      t_self();
      t_window();
      t_ldev_regs();
      t_reenable();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule